// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block computes the signed integer product C = A × B on an N×N grid of multiply-accumulate cells. Before any compute, the host writes the matrix B into the grid one row per cycle. Each cell then keeps its own weight for the whole compute phase. During compute the host presents one row of A per accepted cycle. Input skew registers delay element k of that row by k cycles before it enters grid row k. Activations step one cell to the right on each clock. Partial sums step one cell down on each clock, and a cell in the top row starts from zero.

At the bottom edge, deskew registers line up the N column sums that belong to one row of A. All N values of that result row then leave together with a single valid pulse. A compute run begins with `start` and ends when the host marks a row as the last. `done` pulses together with the result row of that last input. Rows may arrive back to back, which gives one result row per clock, or with idle cycles between them.

Top module: `sysmm_ws`

## Requirements
- R1: After reset, `c_valid` and `done` are low and the weight row pointer points at grid row 0.
- R2: Each cycle in which `w_load` is high while the block is idle writes `w_row` into the grid row given by the pointer, and the pointer then advances, wrapping from N−1 to 0. Element j of `w_row` (bits j*8 and up) becomes B[row][j].
- R3: A `start` asserted in a cycle where `w_load` is high is ignored, so rows presented afterwards produce no results.
- R4: For each accepted row i of A (element k at bits k*8 of `a_row`, signed two's complement), the outputs carry C[i][j] = Σk A[i][k]·B[k][j]. Column j sits at bits j*ACC_W of `c_row`, signed.
- R5: ACC_W = 16 + clog2(N), so sums at the extremes −128 and 127 come out exact, with no wrap.
- R6: All N columns of one result row appear in the same cycle, marked by one `c_valid` pulse. With the accepting cycle counted as cycle 0, that row is on the outputs in cycle 2N, and each accepted row gives exactly one such pulse.
- R7: `done` is high for exactly one cycle, in the same cycle as the `c_valid` of the row accepted with `a_last`. For M rows accepted back to back, this is cycle 2N+M−1 counted from the first accepted row.
- R8: `a_valid` is ignored outside a run, and also after the last row of a run has been accepted. No result comes from such rows.
- R9: Weight load cycles between `start` and `done` are ignored. The stored weights and the pointer stay unchanged, so the run and any later run use the old B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| w_load | input | 1 | Write one weight row this cycle |
| w_row | input | N*8 | Weight row, element j at bits j*8 |
| start | input | 1 | Begin a compute run |
| a_valid | input | 1 | An activation row is presented |
| a_last | input | 1 | The presented row is the last of the run |
| a_row | input | N*8 | Activation row, element k at bits k*8 |
| c_row | output | N*ACC_W | Result row, column j at bits j*ACC_W |
| c_valid | output | 1 | Result row valid |
| done | output | 1 | Last result row of the run is on the outputs |

## Verification
Random signed matrices exercise the general dot product. They would expose a wrong sign extension or a swapped operand. An identity B with random A shows that each element reaches the correct column without being scaled. Matrices filled with −128, or with 127 against −128, push every column sum to its extreme value and show whether the accumulator is wide enough. An alternating pattern of extreme values, fed with idle cycles between rows, separates one diagonal wavefront from the next. Directed runs cover a start raised during a weight load, rows given outside a run or after the last row, and weight writes made while a run is active. In each case the outputs show whether the extra input was ignored.

// File: rtl/sysmm_ws.sv
module sysmm_ws #(
  parameter int N  = 4,
  parameter int DW = 8,
  localparam int ACC_W = 2*DW + $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w_load,
  input  logic [N*DW-1:0]   w_row,
  input  logic              start,
  input  logic              a_valid,
  input  logic              a_last,
  input  logic [N*DW-1:0]   a_row,
  output logic [N*ACC_W-1:0] c_row,
  output logic              c_valid,
  output logic              done
);
  localparam int PW  = $clog2(N);
  localparam int LAT = 2*N - 1;
  localparam logic [PW-1:0] PLAST = PW'(N-1);

  typedef enum logic [1:0] {S_IDLE, S_FEED, S_DRAIN} st_t;

  st_t                   st;
  logic [PW-1:0]         wptr;
  logic [N*N*DW-1:0]     w_q;
  logic [LAT-1:0]        vp, lp;
  logic                  busy, take, fin;
  logic [N*DW-1:0]       a_g;
  logic signed [DW-1:0]    a_in [N][N];
  logic signed [ACC_W-1:0] ps   [N][N];
  logic signed [ACC_W-1:0] al   [N];

  assign busy = (st != S_IDLE);
  assign take = a_valid && (st == S_FEED);
  assign fin  = vp[LAT-1] && lp[LAT-1];
  assign a_g  = take ? a_row : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      wptr <= '0;
      w_q  <= '0;
      vp   <= '0;
      lp   <= '0;
    end else begin
      vp <= {vp[LAT-2:0], take};
      lp <= {lp[LAT-2:0], take && a_last};
      case (st)
        S_IDLE:  if (start && !w_load) st <= S_FEED;
        S_FEED:  if (take && a_last)   st <= S_DRAIN;
        S_DRAIN: if (fin)              st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (w_load && st == S_IDLE) begin
        w_q[wptr*N*DW +: N*DW] <= w_row;
        wptr <= (wptr == PLAST) ? '0 : wptr + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_skew
    if (k == 0) begin : g_direct
      assign a_in[0][0] = a_g[0 +: DW];
    end else begin : g_chain
      logic signed [DW-1:0] sk [k];
      always_ff @(posedge clk) begin
        sk[0] <= a_g[k*DW +: DW];
        for (int i = 1; i < k; i++) sk[i] <= sk[i-1];
      end
      assign a_in[k][0] = sk[k-1];
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_pe
      logic signed [DW-1:0]    wv;
      logic signed [2*DW-1:0]  prod;
      logic signed [ACC_W-1:0] s_in;
      assign wv   = w_q[(k*N+j)*DW +: DW];
      assign prod = a_in[k][j] * wv;
      if (k == 0) begin : g_top
        assign s_in = '0;
      end else begin : g_mid
        assign s_in = ps[k-1][j];
      end
      always_ff @(posedge clk)
        ps[k][j] <= s_in + {{(ACC_W-2*DW){prod[2*DW-1]}}, prod};
      if (j < N-1) begin : g_fwd
        logic signed [DW-1:0] aq;
        always_ff @(posedge clk) aq <= a_in[k][j];
        assign a_in[k][j+1] = aq;
      end
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_deskew
    localparam int D = N - 1 - j;
    if (D == 0) begin : g_pass
      assign al[j] = ps[N-1][j];
    end else begin : g_chain
      logic signed [ACC_W-1:0] dq [D];
      always_ff @(posedge clk) begin
        dq[0] <= ps[N-1][j];
        for (int i = 1; i < D; i++) dq[i] <= dq[i-1];
      end
      assign al[j] = dq[D-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_valid <= 1'b0;
      done    <= 1'b0;
    end else begin
      c_valid <= vp[LAT-1];
      done    <= fin;
    end
  end

  always_ff @(posedge clk)
    for (int j = 0; j < N; j++) c_row[j*ACC_W +: ACC_W] <= al[j];

endmodule

// File: rtl/sysmm_ws_chk.sv
module sysmm_ws_chk #(
  parameter int WQ_W = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            w_load,
  input logic            start,
  input logic            busy,
  input logic            c_valid,
  input logic            done,
  input logic [WQ_W-1:0] w_q
);
  p_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_load && start && !busy) |=> !busy);

  p_valid_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && !done) |-> busy);

  p_done_with_row_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> c_valid);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_weights_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(w_q));
endmodule

bind sysmm_ws sysmm_ws_chk #(.WQ_W(N*N*DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .w_load(w_load), .start(start), .busy(busy),
  .c_valid(c_valid), .done(done), .w_q(w_q)
);

// File: tb/test_sysmm_ws.sv
module test_sysmm_ws;
  localparam int N    = 4;
  localparam int DW   = 8;
  localparam int ACCW = 2*DW + $clog2(N);
  localparam int MAXM = 16;

  // case word: [15:12] pattern, [11:4] rows, [2] gaps, [1] extra row, [0] weight noise
  localparam logic [15:0] CASES [8] = '{
    {4'd0, 8'd4, 4'b0000}, {4'd1, 8'd3, 4'b0000}, {4'd2, 8'd2, 4'b0000},
    {4'd3, 8'd5, 4'b0100}, {4'd4, 8'd6, 4'b0010}, {4'd0, 8'd1, 4'b0000},
    {4'd0, 8'd8, 4'b0001}, {4'd0, 8'd2, 4'b0110}
  };

  logic clk = 0, rst_n = 0;
  logic w_load = 0, start = 0, a_valid = 0, a_last = 0;
  logic [N*DW-1:0]   w_row = '0, a_row = '0;
  logic [N*ACCW-1:0] c_row;
  logic c_valid, done;

  sysmm_ws #(.N(N), .DW(DW)) i_sysmm_ws (
    .clk(clk), .rst_n(rst_n), .w_load(w_load), .w_row(w_row), .start(start),
    .a_valid(a_valid), .a_last(a_last), .a_row(a_row),
    .c_row(c_row), .c_valid(c_valid), .done(done)
  );

  always #10 clk = ~clk;

  int cyc = 0, nchk = 0, nerr = 0;
  int am [MAXM][N];
  int bm [N][N];
  int ex [MAXM][N];
  int acc_cyc [MAXM];
  int nexp = 0, rx = 0, vcount = 0, kind = 0;
  bit done_seen = 0;

  always @(posedge clk) cyc++;

  task automatic check(bit ok, string msg, int act, int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", msg, act, expv);
    end
  endtask

  function automatic int gv(int r, int c, bit isb);
    case (kind)
      1: return -128;
      2: return isb ? -128 : 127;
      3: return isb ? (((r*c) % 2 == 1) ? 127 : -128) : (((r+c) % 2 == 0) ? -128 : 127);
      4: return isb ? ((r == c) ? 1 : 0) : ($urandom_range(0, 255) - 128);
      default: return $urandom_range(0, 255) - 128;
    endcase
  endfunction

  function automatic logic [N*DW-1:0] pack_b(int r);
    logic [N*DW-1:0] v;
    for (int j = 0; j < N; j++) v[j*DW +: DW] = DW'(bm[r][j]);
    return v;
  endfunction

  function automatic logic [N*DW-1:0] pack_a(int i);
    logic [N*DW-1:0] v;
    for (int k = 0; k < N; k++) v[k*DW +: DW] = DW'(am[i][k]);
    return v;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (c_valid) begin
        vcount++;
        if (rx >= nexp) check(1'b0, "R8 result row with no accepted input", rx, nexp);
        else begin
          for (int j = 0; j < N; j++)
            check($signed(c_row[j*ACCW +: ACCW]) == ex[rx][j], "R4/R5 result value",
                  int'($signed(c_row[j*ACCW +: ACCW])), ex[rx][j]);
          check(cyc == acc_cyc[rx] + 2*N, "R6 row latency", cyc, acc_cyc[rx] + 2*N);
          rx++;
        end
      end
      if (done) begin
        check(c_valid, "R7 done without c_valid", 0, 1);
        if (nexp > 0)
          check(cyc == acc_cyc[nexp-1] + 2*N, "R7 done timing", cyc, acc_cyc[nexp-1] + 2*N);
        else
          check(1'b0, "R8 done outside a run", 1, 0);
        done_seen = 1;
      end
    end
  end

  task automatic load_b();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) bm[r][c] = gv(r, c, 1'b1);
    for (int r = 0; r < N; r++) begin
      @(negedge clk); w_load = 1; w_row = pack_b(r);
    end
    @(negedge clk); w_load = 0;
  endtask

  task automatic run(int m, bit gap, bit extra, bit noise);
    for (int i = 0; i < m; i++)
      for (int k = 0; k < N; k++) am[i][k] = gv(i, k, 1'b0);
    for (int i = 0; i < m; i++)
      for (int j = 0; j < N; j++) begin
        ex[i][j] = 0;
        for (int k = 0; k < N; k++) ex[i][j] += am[i][k] * bm[k][j];
      end
    nexp = m; rx = 0; done_seen = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < m; i++) begin
      a_valid = 1; a_row = pack_a(i); a_last = (i == m-1); acc_cyc[i] = cyc;
      if (noise) begin w_load = 1; w_row = {N{8'h5A}}; end
      @(negedge clk);
      a_valid = 0; a_last = 0; w_load = 0;
      if (gap) @(negedge clk);
    end
    if (extra) begin
      a_valid = 1; a_last = 1; a_row = {N{8'h7F}};
      @(negedge clk);
      a_valid = 0; a_last = 0;
    end
    for (int t = 0; t < 4*N + m + 8 && !done_seen; t++) @(negedge clk);
    @(negedge clk);
    check(done_seen, "R7 done seen", done_seen, 1);
    check(rx == m, "R6 one valid pulse per row", rx, m);
  endtask

  task automatic idle_rows(int n);
    int v0;
    v0 = vcount; nexp = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); a_valid = 1; a_last = (i == n-1); a_row = {N{8'h11}};
    end
    @(negedge clk); a_valid = 0; a_last = 0;
    repeat (3*N) @(negedge clk);
    check(vcount == v0, "R8/R3 rows without an active run", vcount - v0, 0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    check(1'b0, "R7 watchdog expired", cyc, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(c_valid == 0, "R1 c_valid after reset", c_valid, 0);
    check(done == 0, "R1 done after reset", done, 0);
    rst_n = 1;
    @(negedge clk);
    check(c_valid == 0 && done == 0, "R1 outputs idle after reset release", c_valid, 0);

    // R8: rows with no run started
    idle_rows(3);

    // R3: start together with the first weight row, then R2 rows 1..N-1 fill the grid
    kind = 0;
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) bm[r][c] = gv(r, c, 1'b1);
    @(negedge clk); w_load = 1; start = 1; w_row = pack_b(0);
    @(negedge clk); start = 0;
    for (int r = 1; r < N; r++) begin
      w_row = pack_b(r);
      @(negedge clk);
    end
    w_load = 0;
    idle_rows(2);
    run(3, 1'b0, 1'b0, 1'b0);   // R2, R4: weights written from pointer 0

    // table of patterns
    for (int t = 0; t < 8; t++) begin
      kind = int'(CASES[t][15:12]);
      load_b();
      run(int'(CASES[t][11:4]), CASES[t][2], CASES[t][1], CASES[t][0]);
      if (CASES[t][0]) begin
        kind = 0;
        run(3, 1'b0, 1'b0, 1'b0);  // R9: old B still in place after ignored writes
      end
    end

    // R2: wrap check, load 2N rows, second pass overwrites the first
    kind = 0;
    load_b();
    load_b();
    run(4, 1'b0, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule